// File: doc/BRIEF.md
# Read-Only Two-Wire Slave for a Captured Data Word

This block answers read transactions on a two-wire (I2C) bus with a 40-bit word that an upstream decoder has captured. The word reaches the block over a valid/ready stream port. It is held in an output bank together with a flag that marks the word as not yet read. A bus master addresses the block for reading and clocks out the five bytes. Once all five bytes have gone out, the word counts as consumed. Every later read returns 0xFF filler until the decoder delivers a fresh word.

The bus lines are brought into the system clock domain before use. SDA is driven open-drain: `sda_oe_o` high pulls the line low. The block never writes and never stretches the clock. A new word is copied into the output bank only while no master holds the block addressed, so a master never sees a word that changes partway through a read. The capture source sees this as back-pressure. It raises `cap_valid_i` with the word on `cap_data_i`, must hold both unchanged while `cap_ready_o` is low, and the word is taken on the clock edge where both are high.

Top module: `i2cro_readout_slave`

## Requirements
- R1: The block acknowledges an address byte of 0x21 when `addr_sel_i` is 1 and 0x23 when it is 0, that is the 7-bit addresses 0x10 and 0x11 with the read bit (LSB) set. Any other address byte, including the right address with the read bit clear, gets no acknowledge and SDA stays released until the next START.
- R2: After the acknowledge, byte k (k = 0..4) carries bits [39-8k : 32-8k] of the output bank, most significant bit first. SDA changes only after a falling SCL edge.
- R3: Any byte requested after the fifth in the same transaction reads 0xFF.
- R4: After reset the bank holds no valid word, and every data byte reads 0xFF.
- R5: While `rst_n` is low, the block acknowledges nothing and keeps `sda_oe_o` low.
- R6: Once the last bit of the fifth byte has been sent, the word becomes invalid. Later reads return all 0xFF until a new word is accepted.
- R7: When `cap_valid_i` and `cap_ready_o` are both high at a clock edge, the word replaces the bank contents and becomes valid.
- R8: `cap_ready_o` is low from the moment the address matches until the next START or STOP on the bus. A word offered in that time waits and is taken after that condition.
- R9: A master not-acknowledge after a byte ends transmission. SDA stays released through any further clocks until the next START, and the word stays valid if fewer than five bytes were sent.
- R10: A START (SDA falling while SCL is high) during any transaction, including a repeated START, restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain) |
| addr_sel_i | input | 1 | Address select: 1 gives 0x21, 0 gives 0x23 |
| cap_data_i | input | NBYTES*8 | Captured word from the decoder |
| cap_valid_i | input | 1 | Captured word offered |
| cap_ready_o | output | 1 | Block can accept the offered word |

## Verification
The bench builds the block with its defaults: five bytes, a two-flop synchronizer and the 0x10/0x11 address pair. With these values the fifth-byte invalidation, the filler beyond the fifth byte and both address-select settings can all be reached in a few short bus transactions. The bus phases are eight system clocks long, well above the synchronizer latency. This lets a word be offered in the middle of a read and shows it being held off until a repeated START or a STOP.

// File: rtl/i2cro_pkg.sv
package i2cro_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHIT,
    ST_AACK,
    ST_TX,
    ST_MACK,
    ST_MNEXT
  } slv_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Full read-address byte for a given 6-bit base and select pin level
  function automatic logic [7:0] read_addr_byte(input logic [5:0] base6, input logic sel);
    return {base6, ~sel, 1'b1};
  endfunction

endpackage

// File: rtl/i2cro_line_sync.sv
module i2cro_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_prev, sda_prev;
  logic scl_lvl, sda_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_ff[STAGES-1];
  assign sda_lvl = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign sda_lvl_o  = sda_lvl;
  assign scl_rise_o = scl_lvl & ~scl_prev;
  assign scl_fall_o = ~scl_lvl & scl_prev;
  assign start_o    = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_o     = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2cro_out_bank.sv
module i2cro_out_bank
  import i2cro_pkg::*;
#(
  parameter int NBYTES = 5,
  localparam int IDXW  = $clog2(NBYTES + 1),
  localparam int DW    = NBYTES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   cap_data_i,
  input  logic            cap_valid_i,
  output logic            cap_ready_o,
  input  logic            busy_i,
  input  logic            consume_i,
  input  logic [IDXW-1:0] byte_idx_i,
  output logic [7:0]      byte_o,
  output logic            valid_o
);

  logic [DW-1:0] bank_q;
  logic          valid_q;
  logic          accept;

  assign cap_ready_o = ~busy_i;
  assign accept      = cap_valid_i & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '1;
      valid_q <= 1'b0;
    end else if (accept) begin
      bank_q  <= cap_data_i;
      valid_q <= 1'b1;
    end else if (consume_i) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    byte_o = FILL_BYTE;
    for (int i = 0; i < NBYTES; i++) begin
      if (valid_q && byte_idx_i == IDXW'(i))
        byte_o = bank_q[(NBYTES-1-i)*8 +: 8];
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/i2cro_slave_fsm.sv
module i2cro_slave_fsm
  import i2cro_pkg::*;
#(
  parameter int         NBYTES = 5,
  parameter logic [5:0] BASE6  = 6'b001000,
  localparam int        IDXW   = $clog2(NBYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_lvl_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            addr_sel_i,
  input  logic [7:0]      tx_byte_i,
  output logic            sda_oe_o,
  output logic            addressed_o,
  output logic [IDXW-1:0] byte_idx_o,
  output logic            consume_o
);

  localparam logic [IDXW-1:0] LAST = IDXW'(NBYTES - 1);
  localparam logic [IDXW-1:0] SAT  = IDXW'(NBYTES);

  slv_state_e      state_q;
  logic [2:0]      bit_q;
  logic [7:0]      sh_q;
  logic [IDXW-1:0] idx_q;
  logic            oe_q;
  logic            addr_q;
  logic [7:0]      addr_shift;

  assign addr_shift = {sh_q[6:0], sda_lvl_i};

  assign consume_o = (state_q == ST_TX) && scl_fall_i && (bit_q == 3'd7) &&
                     (idx_q == LAST) && !start_i && !stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      oe_q    <= 1'b0;
      addr_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
      addr_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      addr_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_q  <= addr_shift;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (addr_shift == read_addr_byte(BASE6, addr_sel_i)) begin
                state_q <= ST_AHIT;
                addr_q  <= 1'b1;
                idx_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_AHIT: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b1;
            state_q <= ST_AACK;
          end
        end
        ST_AACK, ST_MNEXT: begin
          if (scl_fall_i) begin
            sh_q    <= tx_byte_i;
            oe_q    <= ~tx_byte_i[7];
            bit_q   <= '0;
            state_q <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_q == 3'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
              if (idx_q != SAT) idx_q <= idx_q + 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              oe_q  <= ~sh_q[6];
              sh_q  <= {sh_q[6:0], 1'b1};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i)
            state_q <= sda_lvl_i ? ST_IDLE : ST_MNEXT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign addressed_o = addr_q;
  assign byte_idx_o  = idx_q;

endmodule

// File: rtl/i2cro_readout_slave.sv
module i2cro_readout_slave
  import i2cro_pkg::*;
#(
  parameter int         NBYTES      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] BASE6       = 6'b001000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic                addr_sel_i,
  input  logic [NBYTES*8-1:0] cap_data_i,
  input  logic                cap_valid_i,
  output logic                cap_ready_o
);

  localparam int IDXW = $clog2(NBYTES + 1);

  logic            sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic            addressed, consume, bank_valid;
  logic [IDXW-1:0] byte_idx;
  logic [7:0]      tx_byte;

  i2cro_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2cro_slave_fsm #(.NBYTES(NBYTES), .BASE6(BASE6)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_lvl_i   (sda_lvl),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .addr_sel_i  (addr_sel_i),
    .tx_byte_i   (tx_byte),
    .sda_oe_o    (sda_oe_o),
    .addressed_o (addressed),
    .byte_idx_o  (byte_idx),
    .consume_o   (consume)
  );

  i2cro_out_bank #(.NBYTES(NBYTES)) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_data_i  (cap_data_i),
    .cap_valid_i (cap_valid_i),
    .cap_ready_o (cap_ready_o),
    .busy_i      (addressed),
    .consume_i   (consume),
    .byte_idx_i  (byte_idx),
    .byte_o      (tx_byte),
    .valid_o     (bank_valid)
  );

endmodule

// File: rtl/i2cro_readout_chk.sv
module i2cro_readout_chk #(
  parameter int  NBYTES = 5,
  localparam int IDXW   = $clog2(NBYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sda_oe,
  input logic            scl_fall,
  input logic            bus_start,
  input logic            bus_stop,
  input logic            cap_valid,
  input logic            cap_ready,
  input logic            data_valid,
  input logic [IDXW-1:0] byte_idx,
  input logic [7:0]      tx_byte
);

  // R2
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !cap_ready);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_ready) |=> data_valid);

  // R6
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> ($past(byte_idx) == IDXW'(NBYTES - 1)));

  // R3
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_idx == IDXW'(NBYTES)) |-> (tx_byte == 8'hFF));

  always @(posedge clk) begin
    if (!rst_n) begin
      // R5
      reset_quiet_chk: assert (!sda_oe);
      // R4
      reset_empty_chk: assert (!data_valid);
    end
  end

endmodule

bind i2cro_readout_slave i2cro_readout_chk #(.NBYTES(NBYTES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe_o),
  .scl_fall   (scl_fall),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .cap_valid  (cap_valid_i),
  .cap_ready  (cap_ready_o),
  .data_valid (bank_valid),
  .byte_idx   (byte_idx),
  .tx_byte    (tx_byte)
);

// File: tb/i2cro_readout_slave_tb_top.sv
module i2cro_readout_slave_tb_top;

  localparam int PH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_sel = 1'b1;
  logic [39:0] cap_data = '0;
  logic        cap_valid = 1'b0;
  logic        sda_oe, cap_ready;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [39:0] m_bank = '1;
  logic        m_valid = 1'b0;
  int          m_idx = 0;

  logic guard = 1'b0;
  logic guard_hit = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2cro_readout_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .addr_sel_i  (addr_sel),
    .cap_data_i  (cap_data),
    .cap_valid_i (cap_valid),
    .cap_ready_o (cap_ready)
  );

  // every-clock monitor: flags SDA drive inside a no-drive window
  always @(negedge clk) if (guard && sda_oe) guard_hit <= 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; ph();
    scl_m = 1'b1; ph();
    sda_m = 1'b0; ph();
    scl_m = 1'b0; ph();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; ph();
    scl_m = 1'b1; ph();
    sda_m = 1'b1; ph();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; ph();
      scl_m = 1'b1; ph();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; ph();
    scl_m = 1'b1; ph();
    ack = ~sda_bus;
    scl_m = 1'b0; ph();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      ph();
      scl_m = 1'b1; ph();
      b[i] = sda_bus;
      scl_m = 1'b0;
    end
    ph();
    sda_m = ~give_ack; ph();
    scl_m = 1'b1; ph();
    scl_m = 1'b0; ph();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    if (!m_valid || k >= 5) return 8'hFF;
    return m_bank[(4-k)*8 +: 8];
  endfunction

  // read n bytes and compare with the model; last byte NACKed
  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, b);
      chk(req, b, exp_byte(m_idx));
      if (m_idx == 4) m_valid = 1'b0;
      m_idx++;
    end
  endtask

  task automatic address(input logic [7:0] a, input logic exp_ack, input string req);
    logic ack;
    bus_start();
    m_idx = 0;
    send_byte(a, ack);
    chk(req, ack, exp_ack);
  endtask

  task automatic offer(input logic [39:0] d);
    @(negedge clk);
    cap_data = d;
    cap_valid = 1'b1;
  endtask

  task automatic complete_offer();
    while (!cap_ready) @(negedge clk);
    m_bank = cap_data;
    m_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5: address attempt while reset is held
    repeat (3) @(negedge clk);
    guard = 1'b1;
    address(8'h21, 1'b0, "R5 ack during reset");
    bus_stop();
    chk("R5 sda released during reset", guard_hit, 1'b0);
    guard = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: reset state
    chk("R4 sda_oe after reset", sda_oe, 1'b0);
    chk("R7 cap_ready idle", cap_ready, 1'b1);
    address(8'h21, 1'b1, "R1 addr 0x21 sel=1");
    read_bytes(5, "R4 filler after reset");
    bus_stop();

    // R7, R2, R3: fresh word, read seven bytes
    offer(40'h1A2B3C4D5E);
    complete_offer();
    address(8'h21, 1'b1, "R1 addr 0x21 sel=1");
    read_bytes(7, "R2 R3 order and filler");
    bus_stop();

    // R6: consumed word reads as filler
    address(8'h21, 1'b1, "R1 addr 0x21 sel=1");
    read_bytes(5, "R6 invalid after read");
    bus_stop();

    // R1: wrong address and write direction
    guard_hit = 1'b0; guard = 1'b1;
    address(8'h23, 1'b0, "R1 0x23 with sel=1");
    address(8'h20, 1'b0, "R1 write bit clear");
    bus_stop();
    guard = 1'b0;
    chk("R1 sda released on mismatch", guard_hit, 1'b0);

    // R1: other select level
    addr_sel = 1'b0;
    offer(40'h0F1E2D3C4B);
    complete_offer();
    address(8'h21, 1'b0, "R1 0x21 with sel=0");
    address(8'h23, 1'b1, "R1 0x23 with sel=0");

    // R9: early NACK, then extra clocks, word stays valid
    read_bytes(2, "R2 partial read");
    guard_hit = 1'b0; guard = 1'b1;
    for (int i = 0; i < 9; i++) begin
      ph(); scl_m = 1'b1; ph(); scl_m = 1'b0;
    end
    bus_stop();
    guard = 1'b0;
    chk("R9 released after nack", guard_hit, 1'b0);

    // R8, R10: offer mid-read, repeated START releases it
    address(8'h23, 1'b1, "R1 0x23 with sel=0");
    read_bytes(1, "R9 word kept after nack");
    // rewind: the single-byte read above ended with NACK; re-address
    address(8'h23, 1'b1, "R10 repeated start re-address");
    chk("R8 not ready while addressed", cap_ready, 1'b0);
    read_bytes(2, "R10 restart from byte 0");
    m_idx = 0;
    bus_start();
    begin
      logic ack;
      send_byte(8'h23, ack);
      chk("R10 ack after repeated start", ack, 1'b1);
    end
    offer(40'hC35A96E187);
    repeat (20) @(negedge clk);
    chk("R8 offer held while addressed", cap_ready, 1'b0);
    read_bytes(5, "R8 old word during pending offer");
    bus_start();
    complete_offer();
    m_idx = 0;
    begin
      logic ack;
      send_byte(8'h23, ack);
      chk("R10 ack after restart", ack, 1'b1);
    end
    read_bytes(6, "R8 word taken at restart");
    bus_stop();

    // R8: offer released by STOP
    address(8'h23, 1'b1, "R1 0x23 with sel=0");
    offer(40'h5566778899);
    repeat (20) @(negedge clk);
    chk("R8 held before stop", cap_ready, 1'b0);
    read_bytes(1, "R6 filler after consume");
    bus_stop();
    complete_offer();
    address(8'h23, 1'b1, "R1 0x23 with sel=0");
    read_bytes(5, "R7 word taken after stop");
    bus_stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule